// File: doc/BRIEF.md
# Memory clock-stop controller

This block sits between a low-power DDR command scheduler and the memory pins. It forwards the scheduler's commands, tracks how long each issued command still needs the memory clock (including the data-out beats of a read burst and the recovery window of every command), and gates the memory clock off once a stop has been asked for and nothing is outstanding. The clock-enable input of the memory stays high the whole time, so this is a clock stop and not a power-down.

A one-cycle stop pulse from the system is held until every timing window has run out. The clock is then parked with the true phase low and the complementary phase high. A one-cycle wake pulse restarts the clock, and a programmable number of NOP cycles (at least one) is driven before the scheduler gets a one-cycle acknowledge and may send commands again. A wake that arrives while a stop is still waiting cancels the stop, and the clock is never gated. The clock-enable for the external gate changes only on the falling edge of the controller clock, so the gated clock gets no runt pulse.

Top module: `lpclk_stop_ctrl`

## Requirements
- R1: Command codes on cmd_i and mem_cmd_o are 3 bits: NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE SET=6. While cmd_ready_o is high, mem_cmd_o equals cmd_i when cmd_valid_i is high and NOP otherwise. Out of reset cmd_ready_o and clk_en_o are high and wake_ack_o is low.
- R2: With no window running, a one-cycle stop_req_i pulse leaves exactly one further memory clock rising edge after the edge that samples it, and then clk_en_o is low.
- R3: A command issued at an edge loads a window of W cycles (ACTIVATE 3, READ 5 covering the burst data-out, WRITE 6, PRECHARGE 3, REFRESH 10, MODE SET 2 by default). With a stop pending, exactly W+1 further memory clock rising edges follow, all carrying NOP, before the clock stops. The clock never stops while a window is running.
- R4: While clk_en_o is low, ck_t_o is held low and ck_c_o is held high.
- R5: cke_o is high at all times, including while the clock is stopped.
- R6: clk_en_o changes only while clk_i is low.
- R7: A one-cycle wake_req_i pulse while stopped restarts the clock. The first restarted edge and the next N-1 edges carry NOP, where N is restart_nops_i, and a value of 0 counts as 1. Then cmd_ready_o returns high, and wake_ack_o is high for exactly that first ready cycle.
- R8: A wake_req_i pulse while a stop is waiting for its windows cancels the stop. clk_en_o stays high, cmd_ready_o stays high, and no wake_ack_o is given.
- R9: While the clock is stopped or restarting, cmd_ready_o is low and mem_cmd_o is NOP whatever cmd_i and cmd_valid_i are.
- R10: stop_req_i while stopped and wake_req_i while running are ignored. No clock edge is added or removed, and no acknowledge is given.
- R11: A command accepted while a stop is waiting is forwarded and reloads its own window, so the stop is pushed back to W+1 edges after that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Scheduler command valid |
| cmd_i | input | 3 | Scheduler command code |
| cmd_ready_o | output | 1 | Commands may be issued this cycle |
| stop_req_i | input | 1 | One-cycle clock-stop request |
| wake_req_i | input | 1 | One-cycle wake request |
| restart_nops_i | input | NOP_W | NOP cycles to drive on restart (0 counts as 1) |
| wake_ack_o | output | 1 | One-cycle pulse when commands are accepted again after restart |
| mem_cmd_o | output | 3 | Command driven to the memory |
| clk_en_o | output | 1 | Enable for the external clock gate |
| ck_t_o | output | 1 | Gated true memory clock |
| ck_c_o | output | 1 | Gated complementary memory clock |
| cke_o | output | 1 | Memory clock-enable pin, held high |

## Verification
The bench counts every enabled memory clock edge and every non-NOP command driven on those edges. It checks that each command window produces exactly W+1 trailing NOP edges before the clock is gated: a drain that is too short would stop the clock before a read burst or a recovery time ends, and one that is too long shows up as extra edges. Restart is checked for 0, 1 and several NOPs, since an off-by-one there lets an access command reach the first restarted edge or gives a late acknowledge. A command issued during drain must push the stop back, a wake during drain must leave the clock running with no acknowledge, and any enable change while the clock is high is reported as a possible runt pulse.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } mem_cmd_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_DRAIN,
    ST_STOPPED,
    ST_RESTART
  } stop_st_e;

  localparam int unsigned NUM_WIN = 6;
endpackage

// File: rtl/lpclk_win_cnt.sv
module lpclk_win_cnt #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LEN   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lpclk_safe_track.sv
module lpclk_safe_track
  import lpclk_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RD  = 5,
  parameter int unsigned T_WR  = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 10,
  parameter int unsigned T_MRD = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [2:0] cmd_i,
  output logic       safe_o
);
  // index g serves command code g+1
  localparam int unsigned WIN_LEN [NUM_WIN] = '{T_RCD, T_RD, T_WR, T_RP, T_RFC, T_MRD};

  logic [NUM_WIN-1:0] busy;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    lpclk_win_cnt #(
      .CNT_W(CNT_W),
      .LEN  (WIN_LEN[g])
    ) u_win (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(issue_i && (cmd_i == 3'(g + 1))),
      .busy_o(busy[g])
    );
  end

  assign safe_o = ~|busy && !issue_i;
endmodule

// File: rtl/lpclk_clk_gate.sv
module lpclk_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  output logic clk_en_o,
  output logic ck_t_o,
  output logic ck_c_o
);
  logic en_q;

  // enable moves on the falling edge only: no runt pulse on the gated clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_req_i;
  end

  assign clk_en_o = en_q;
  assign ck_t_o   = clk_i & en_q;
  assign ck_c_o   = ~ck_t_o;
endmodule

// File: rtl/lpclk_stop_fsm.sv
module lpclk_stop_fsm
  import lpclk_pkg::*;
#(
  parameter int unsigned NOP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_req_i,
  input  logic             safe_i,
  input  logic [NOP_W-1:0] restart_nops_i,
  output stop_st_e         state_o,
  output logic             wake_ack_o
);
  stop_st_e         state_q, state_d;
  logic [NOP_W-1:0] nop_cnt_q;
  logic             ack_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (stop_req_i && !wake_req_i) state_d = ST_DRAIN;
      ST_DRAIN:   if (wake_req_i)                state_d = ST_RUN;
                  else if (safe_i)               state_d = ST_STOPPED;
      ST_STOPPED: if (wake_req_i)                state_d = ST_RESTART;
      ST_RESTART: if (nop_cnt_q <= NOP_W'(1))    state_d = ST_RUN;
      default:                                   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      nop_cnt_q <= '0;
      ack_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_RESTART) && (state_d == ST_RUN);
      if (state_q == ST_STOPPED && wake_req_i)
        nop_cnt_q <= (restart_nops_i == '0) ? NOP_W'(1) : restart_nops_i;
      else if (state_q == ST_RESTART && nop_cnt_q > NOP_W'(1))
        nop_cnt_q <= nop_cnt_q - 1'b1;
    end
  end

  assign state_o    = state_q;
  assign wake_ack_o = ack_q;
endmodule

// File: rtl/lpclk_stop_ctrl.sv
module lpclk_stop_ctrl
  import lpclk_pkg::*;
#(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RD  = 5,
  parameter int unsigned T_WR  = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 10,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned NOP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  output logic             cmd_ready_o,
  input  logic             stop_req_i,
  input  logic             wake_req_i,
  input  logic [NOP_W-1:0] restart_nops_i,
  output logic             wake_ack_o,
  output logic [2:0]       mem_cmd_o,
  output logic             clk_en_o,
  output logic             ck_t_o,
  output logic             ck_c_o,
  output logic             cke_o
);
  localparam int unsigned CNT_W = $clog2(T_RCD + T_RD + T_WR + T_RP + T_RFC + T_MRD + 1);

  stop_st_e state_w;
  logic     safe_w;
  logic     issue_w;
  logic     pass_w;

  assign cmd_ready_o = (state_w == ST_RUN) || (state_w == ST_DRAIN);
  assign pass_w      = cmd_ready_o && cmd_valid_i;
  assign issue_w     = pass_w && (cmd_i != CMD_NOP);
  assign mem_cmd_o   = pass_w ? cmd_i : CMD_NOP;
  assign cke_o       = 1'b1;

  lpclk_safe_track #(
    .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RD(T_RD), .T_WR(T_WR),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(issue_w),
    .cmd_i  (cmd_i),
    .safe_o (safe_w)
  );

  lpclk_stop_fsm #(.NOP_W(NOP_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_req_i    (stop_req_i),
    .wake_req_i    (wake_req_i),
    .safe_i        (safe_w),
    .restart_nops_i(restart_nops_i),
    .state_o       (state_w),
    .wake_ack_o    (wake_ack_o)
  );

  lpclk_clk_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_req_i(state_w != ST_STOPPED),
    .clk_en_o(clk_en_o),
    .ck_t_o  (ck_t_o),
    .ck_c_o  (ck_c_o)
  );
endmodule

// File: rtl/lpclk_stop_ctrl_chk.sv
module lpclk_stop_ctrl_chk
  import lpclk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_en_o,
  input logic       ck_t_o,
  input logic       ck_c_o,
  input logic [2:0] mem_cmd_o,
  input logic       cmd_ready_o,
  input logic       wake_ack_o,
  input logic       wake_req_i,
  input logic       safe_i,
  input stop_st_e   state_i
);
  AST_PARK_LEVELS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (!ck_t_o && ck_c_o)); // R4

  AST_GATE_ONLY_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $past(safe_i)); // R3

  AST_FIRST_EDGE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !$past(clk_en_o)) |-> (mem_cmd_o == CMD_NOP)); // R7

  AST_ACK_AFTER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ack_o |-> (cmd_ready_o && $past(state_i == ST_RESTART))); // R7

  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (!cmd_ready_o && mem_cmd_o == CMD_NOP)); // R9

  AST_READY_NEEDS_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> clk_en_o); // R9

  AST_WAKE_CANCELS_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DRAIN && wake_req_i) |=> (state_i == ST_RUN && clk_en_o)); // R8
endmodule

bind lpclk_stop_ctrl lpclk_stop_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_o   (clk_en_o),
  .ck_t_o     (ck_t_o),
  .ck_c_o     (ck_c_o),
  .mem_cmd_o  (mem_cmd_o),
  .cmd_ready_o(cmd_ready_o),
  .wake_ack_o (wake_ack_o),
  .wake_req_i (wake_req_i),
  .safe_i     (safe_w),
  .state_i    (state_w)
);

// File: tb/lpclk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module lpclk_stop_ctrl_bench;
  localparam int NOP_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_i = 3'd0;
  logic             stop_req_i = 1'b0;
  logic             wake_req_i = 1'b0;
  logic [NOP_W-1:0] restart_nops_i = 4'd1;
  logic             cmd_ready_o, wake_ack_o, clk_en_o, ck_t_o, ck_c_o, cke_o;
  logic [2:0]       mem_cmd_o;

  lpclk_stop_ctrl u_lpclk_stop_ctrl (.*);

  always #4 clk_i = ~clk_i; // 125 MHz

  int checks = 0, fails = 0;
  int edges = 0, nonnop = 0, stopped = 0, acks = 0, gate_bad = 0;
  bit done = 0;

  // snapshot 1 ns before each rising edge: what the memory will sample
  always @(negedge clk_i) begin
    #3;
    if (rst_ni && clk_en_o) begin
      edges++;
      if (mem_cmd_o != 3'd0) nonnop++;
    end
    if (rst_ni && !clk_en_o) stopped++;
    if (wake_ack_o) acks++;
  end

  always @(clk_en_o) if (rst_ni && clk_i === 1'b1) gate_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  task automatic t_reset();
    chk(cmd_ready_o == 1'b1, "R1 ready after reset", int'(cmd_ready_o), 1);
    chk(clk_en_o == 1'b1, "R1 clock on after reset", int'(clk_en_o), 1);
    chk(wake_ack_o == 1'b0, "R1 no ack after reset", int'(wake_ack_o), 0);
    chk(cke_o == 1'b1, "R5 cke high", int'(cke_o), 1);
  endtask

  task automatic t_pass();
    cmd_i = 3'd3; cmd_valid_i = 1'b0; #1;
    chk(mem_cmd_o == 3'd0, "R1 invalid gives NOP", int'(mem_cmd_o), 0);
    cmd_valid_i = 1'b1; cmd_i = 3'd1; #1;
    chk(mem_cmd_o == 3'd1, "R1 forward ACTIVATE", int'(mem_cmd_o), 1);
    cyc(); cmd_valid_i = 1'b0;
    repeat (12) cyc();
  endtask

  task automatic t_wake(input int n);
    int b, a, nn, k;
    b = edges; a = acks; nn = nonnop;
    restart_nops_i = NOP_W'(n);
    wake_req_i = 1'b1; cmd_valid_i = 1'b1; cmd_i = 3'd2;
    cyc(); wake_req_i = 1'b0;
    k = 0;
    while (!cmd_ready_o && k < 20) begin cyc(); k++; end
    cmd_valid_i = 1'b0;
    chk(edges - b == (n == 0 ? 1 : n), "R7 restart NOP edges", edges - b, (n == 0 ? 1 : n));
    chk(nonnop - nn == 0, "R7 restart edges carry NOP", nonnop - nn, 0);
    chk(wake_ack_o == 1'b1, "R7 ack on first ready cycle", int'(wake_ack_o), 1);
    cyc();
    chk(wake_ack_o == 1'b0 && acks - a == 1, "R7 ack one cycle", acks - a, 1);
  endtask

  task automatic t_idle_stop();
    int b;
    b = edges;
    stop_req_i = 1'b1; cyc(); stop_req_i = 1'b0;
    repeat (8) cyc();
    chk(edges - b == 2, "R2 idle stop edges", edges - b, 2);
    chk(clk_en_o == 1'b0, "R2 clock gated", int'(clk_en_o), 0);
    @(posedge clk_i); #1;
    chk(ck_t_o == 1'b0 && ck_c_o == 1'b1, "R4 park levels", {ck_t_o, ck_c_o}, 1);
    chk(cke_o == 1'b1, "R5 cke high while stopped", int'(cke_o), 1);
    cyc();
    cmd_valid_i = 1'b1; cmd_i = 3'd3; #1;
    chk(cmd_ready_o == 1'b0 && mem_cmd_o == 3'd0, "R9 stopped blocks command",
        int'(mem_cmd_o), 0);
    cmd_valid_i = 1'b0;
    b = edges;
    stop_req_i = 1'b1; cyc(); stop_req_i = 1'b0;
    repeat (5) cyc();
    chk(edges - b == 0 && clk_en_o == 1'b0, "R10 stop while stopped ignored", edges - b, 0);
    t_wake(3);
  endtask

  task automatic t_cmd_stop(input logic [2:0] code, input int w, input int nops);
    int b, nn;
    b = edges; nn = nonnop;
    cmd_valid_i = 1'b1; cmd_i = code; stop_req_i = 1'b1;
    cyc(); cmd_valid_i = 1'b0; stop_req_i = 1'b0;
    repeat (w + 8) cyc();
    chk(edges - b == w + 2, $sformatf("R3 drain edges code %0d", code), edges - b, w + 2);
    chk(nonnop - nn == 1, $sformatf("R3 trailing NOPs code %0d", code), nonnop - nn, 1);
    chk(clk_en_o == 1'b0, "R3 stopped after window", int'(clk_en_o), 0);
    t_wake(nops);
  endtask

  task automatic t_extend();
    int b, nn;
    b = edges; nn = nonnop;
    cmd_valid_i = 1'b1; cmd_i = 3'd1; stop_req_i = 1'b1;
    cyc(); cmd_valid_i = 1'b0; stop_req_i = 1'b0;
    cyc();
    cmd_valid_i = 1'b1; cmd_i = 3'd3;
    cyc(); cmd_valid_i = 1'b0;
    repeat (15) cyc();
    chk(edges - b == 10, "R11 drain pushed back by WRITE", edges - b, 10);
    chk(nonnop - nn == 2, "R11 both commands forwarded", nonnop - nn, 2);
    t_wake(1);
  endtask

  task automatic t_cancel();
    int s, a;
    s = stopped; a = acks;
    cmd_valid_i = 1'b1; cmd_i = 3'd5; stop_req_i = 1'b1;
    cyc(); cmd_valid_i = 1'b0; stop_req_i = 1'b0;
    repeat (3) cyc();
    wake_req_i = 1'b1; cyc(); wake_req_i = 1'b0;
    repeat (20) cyc();
    chk(stopped - s == 0 && clk_en_o == 1'b1, "R8 clock never gated", stopped - s, 0);
    chk(cmd_ready_o == 1'b1 && acks - a == 0, "R8 no ack on cancel", acks - a, 0);
  endtask

  task automatic t_wake_running();
    int s, a;
    s = stopped; a = acks;
    wake_req_i = 1'b1; cyc(); wake_req_i = 1'b0;
    repeat (6) cyc();
    chk(acks - a == 0 && stopped - s == 0 && cmd_ready_o, "R10 wake while running ignored",
        acks - a, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_pass();
    t_idle_stop();
    t_cmd_stop(3'd1, 3, 0);
    t_cmd_stop(3'd2, 5, 1);
    t_cmd_stop(3'd3, 6, 2);
    t_cmd_stop(3'd4, 3, 1);
    t_cmd_stop(3'd5, 10, 4);
    t_cmd_stop(3'd6, 2, 1);
    t_extend();
    t_cancel();
    t_wake_running();
    chk(gate_bad == 0, "R6 enable moved while clock high", gate_bad, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule